// File: doc/BRIEF.md
# Single-Channel Memory Copy and Pattern Fill DMA

This block is one memory-to-memory DMA channel. Software programs a byte count, a source address, a destination address and an optional pointer to a further descriptor through a small word-addressed register port. It then sets the run bit in the control register. The channel moves data in 8-byte beats over a request/acknowledge memory port. Each beat is one read from the source followed by one write to the destination. The count drops by 8 per beat, and both addresses advance by 8.

Clearing the run bit while the channel is busy pauses it at the next beat boundary, and setting the bit again resumes from the saved addresses and count. A kill bit ends the transfer at once, even with a memory request outstanding. With the source-hold bit set, the source address never moves, so one 64-bit word is repeated across the destination range as a fill. When the count reaches zero and the descriptor pointer is nonzero, the channel reads a four-word descriptor from that pointer and continues. When the pointer is zero, the channel stops and records completion in a cause register, which can raise an interrupt through a mask register.

Top module: `dma_fill_chan`

## Requirements
- R1: After reset every register reads zero, and `irq` and `mem_req` are low.
- R2: Control register (word 0) bits are: run bit 0, source-hold bit 1, wide-count bit 2, kill bit 3 (write only, reads 0), busy bit 4 (read only). Writing run=1 while idle starts the programmed transfer. Busy=1 with run=1 means running, busy=1 with run=0 means paused, and busy=0 means idle.
- R3: Each beat reads 8 bytes at the source address and writes them at the destination address. The count register (word 1) then drops by 8, and the destination (word 3) and source (word 2) each advance by 8.
- R4: With source-hold set, the source address stays fixed for the whole transfer, and every destination word receives the same source word.
- R5: When the count is zero and the next-descriptor pointer (word 4) is zero, the channel goes idle, clears run and sets cause bit 0. A start with a zero count completes without any memory write.
- R6: Clearing run while busy lets the current beat finish and then issues no further request. Busy stays set, and count and addresses hold. Setting run again resumes the transfer to completion.
- R7: Writing the kill bit drops `mem_req` in the cycle after the write, returns the channel to idle with run cleared, sets cause bit 1 and leaves the remaining count readable.
- R8: At zero count with a nonzero next pointer, the channel reads 32-bit words from pointer+0, +4, +8 and +12 into count, source, destination and next pointer (taken from `mem_rdata[31:0]`). The current-descriptor register (word 5) takes the pointer value, and the transfer continues.
- R9: With wide-count clear, only the low 16 bits of a count are used, both at start and on a descriptor load. With wide-count set, all 24 bits are used.
- R10: A write to the cause register (word 7) ANDs it with the written data, so writing zero clears every cause. `irq` is high while any cause bit has its bit set in the mask register (word 8). Word 6 is a plain 32-bit storage register.
- R11: Writes to count, source, destination and next pointer are ignored while busy, whether running or paused.
- R12: A memory request, once raised, keeps its address and direction until acknowledged, unless a kill withdraws it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request accepted and completed this cycle |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| irq | output | 1 | Unmasked cause pending |

## Verification
On every cycle the assertions check these properties:
- a completed beat lowers the count by exactly one beat;
- source-hold freezes the source address;
- a pending request keeps its address until acknowledged;
- a paused channel raises no new request;
- kill reaches idle in one cycle;
- completion sets its cause bit;
- writes to the transfer registers are ignored while busy.

Only the bench's scenarios can show that whole transfers are correct. These scenarios cover the data that lands in memory for plain copy and fill, the 16-bit count truncation, descriptor chaining with the current-pointer update, resume after a pause, the remaining count after a kill, and the interplay of cause and mask on `irq`.

// File: rtl/dma_fill_pkg.sv
package dma_fill_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DESC  = 3'd4
  } chan_state_e;

  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] RA_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] RA_COUNT = 4'd1;
  localparam logic [REG_AW-1:0] RA_SRC   = 4'd2;
  localparam logic [REG_AW-1:0] RA_DST   = 4'd3;
  localparam logic [REG_AW-1:0] RA_NEXT  = 4'd4;
  localparam logic [REG_AW-1:0] RA_CUR   = 4'd5;
  localparam logic [REG_AW-1:0] RA_AUX   = 4'd6;
  localparam logic [REG_AW-1:0] RA_CAUSE = 4'd7;
  localparam logic [REG_AW-1:0] RA_MASK  = 4'd8;

  localparam int CB_GO   = 0;
  localparam int CB_HOLD = 1;
  localparam int CB_WIDE = 2;
  localparam int CB_KILL = 3;
  localparam int CB_BUSY = 4;

  localparam int CZ_DONE  = 0;
  localparam int CZ_ABORT = 1;
  localparam int CZ_W     = 2;

endpackage

// File: rtl/dma_fill_fsm.sv
module dma_fill_fsm
  import dma_fill_pkg::*;
#(
  parameter int DESC_WORDS = 4,
  localparam int DIW = $clog2(DESC_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           kill,
  input  logic           cnt_zero,
  input  logic           next_zero,
  input  logic           mem_ack,
  output chan_state_e    state,
  output logic [DIW-1:0] desc_idx,
  output logic           mem_req,
  output logic           mem_we,
  output logic           rd_done,
  output logic           beat_done,
  output logic           desc_ld,
  output logic           chain_start,
  output logic           start_evt,
  output logic           finish_evt,
  output logic           abort_evt,
  output logic           busy
);

  localparam logic [DIW-1:0] LAST_IDX = DIW'(DESC_WORDS - 1);

  chan_state_e nxt;

  always_comb begin
    nxt         = state;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    rd_done     = 1'b0;
    beat_done   = 1'b0;
    desc_ld     = 1'b0;
    chain_start = 1'b0;
    start_evt   = 1'b0;
    finish_evt  = 1'b0;
    abort_evt   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (go && !kill) begin
          nxt       = ST_ISSUE;
          start_evt = 1'b1;
        end
      end
      ST_ISSUE: begin
        if (kill) begin
          nxt       = ST_IDLE;
          abort_evt = 1'b1;
        end else if (go) begin
          if (!cnt_zero) begin
            nxt = ST_READ;
          end else if (!next_zero) begin
            nxt         = ST_DESC;
            chain_start = 1'b1;
          end else begin
            nxt        = ST_IDLE;
            finish_evt = 1'b1;
          end
        end
      end
      ST_READ: begin
        mem_req = !kill;
        if (kill) begin
          nxt       = ST_IDLE;
          abort_evt = 1'b1;
        end else if (mem_ack) begin
          rd_done = 1'b1;
          nxt     = ST_WRITE;
        end
      end
      ST_WRITE: begin
        mem_req = !kill;
        mem_we  = !kill;
        if (kill) begin
          nxt       = ST_IDLE;
          abort_evt = 1'b1;
        end else if (mem_ack) begin
          beat_done = 1'b1;
          nxt       = ST_ISSUE;
        end
      end
      ST_DESC: begin
        mem_req = !kill;
        if (kill) begin
          nxt       = ST_IDLE;
          abort_evt = 1'b1;
        end else if (mem_ack) begin
          desc_ld = 1'b1;
          if (desc_idx == LAST_IDX) nxt = ST_ISSUE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      desc_idx <= '0;
    end else begin
      state <= nxt;
      if (chain_start)  desc_idx <= '0;
      else if (desc_ld) desc_idx <= desc_idx + 1'b1;
    end
  end

  // R7: a kill leaves the channel idle one cycle later
  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !busy);

  // R12: a request is not withdrawn before its acknowledge except by a kill
  p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req || kill));

endmodule

// File: rtl/dma_fill_regs.sv
module dma_fill_regs
  import dma_fill_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 24,
  parameter int NW   = 16,
  parameter int BEAT = 8,
  parameter int DIW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              busy,
  input  logic              start_evt,
  input  logic              beat_done,
  input  logic              chain_start,
  input  logic              desc_ld,
  input  logic [DIW-1:0]    desc_idx,
  input  logic [31:0]       desc_word,
  input  logic              finish_evt,
  input  logic              abort_evt,
  output logic              go,
  output logic              hold,
  output logic              wide,
  output logic              kill,
  output logic [CW-1:0]     count,
  output logic [AW-1:0]     src,
  output logic [AW-1:0]     dst,
  output logic [AW-1:0]     nxt_ptr,
  output logic [AW-1:0]     cur_ptr,
  output logic [31:0]       aux
);

  // Count as used by the engine: narrow mode keeps only NW bits.
  function automatic logic [CW-1:0] f_trim(input logic [CW-1:0] c, input logic w);
    f_trim = w ? c : {{(CW-NW){1'b0}}, c[NW-1:0]};
  endfunction

  // Address after one beat; a held address does not move.
  function automatic logic [AW-1:0] f_adv(input logic [AW-1:0] a, input logic fixed);
    f_adv = fixed ? a : a + AW'(BEAT);
  endfunction

  logic ctrl_wr, data_wr;
  assign ctrl_wr = cfg_we && (cfg_addr == RA_CTRL);
  assign data_wr = cfg_we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go      <= 1'b0;
      hold    <= 1'b0;
      wide    <= 1'b0;
      kill    <= 1'b0;
      count   <= '0;
      src     <= '0;
      dst     <= '0;
      nxt_ptr <= '0;
      cur_ptr <= '0;
      aux     <= '0;
    end else begin
      kill <= ctrl_wr && cfg_wdata[CB_KILL];
      if (ctrl_wr) begin
        go   <= cfg_wdata[CB_GO];
        hold <= cfg_wdata[CB_HOLD];
        wide <= cfg_wdata[CB_WIDE];
      end
      if (cfg_we && (cfg_addr == RA_AUX)) aux <= cfg_wdata;
      if (data_wr) begin
        unique case (cfg_addr)
          RA_COUNT: count   <= cfg_wdata[CW-1:0];
          RA_SRC:   src     <= cfg_wdata[AW-1:0];
          RA_DST:   dst     <= cfg_wdata[AW-1:0];
          RA_NEXT:  nxt_ptr <= cfg_wdata[AW-1:0];
          default: ;
        endcase
      end
      if (start_evt) count <= f_trim(count, wide);
      if (beat_done) begin
        count <= count - CW'(BEAT);
        dst   <= f_adv(dst, 1'b0);
        src   <= f_adv(src, hold);
      end
      if (chain_start) cur_ptr <= nxt_ptr;
      if (desc_ld) begin
        unique case (desc_idx)
          2'd0:    count   <= f_trim(desc_word[CW-1:0], wide);
          2'd1:    src     <= desc_word[AW-1:0];
          2'd2:    dst     <= desc_word[AW-1:0];
          default: nxt_ptr <= desc_word[AW-1:0];
        endcase
      end
      if (finish_evt || abort_evt || kill) go <= 1'b0;
    end
  end

  // R11: software cannot change the count while the channel is busy
  p_ignore_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && busy && (cfg_addr == RA_COUNT) && !beat_done && !desc_ld)
      |=> $stable(count));

endmodule

// File: rtl/dma_fill_irq.sv
module dma_fill_irq
  import dma_fill_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              finish_evt,
  input  logic              abort_evt,
  output logic [CZ_W-1:0]   cause,
  output logic [CZ_W-1:0]   mask,
  output logic              irq
);

  logic [CZ_W-1:0] set_vec;
  always_comb begin
    set_vec           = '0;
    set_vec[CZ_DONE]  = finish_evt;
    set_vec[CZ_ABORT] = abort_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause <= '0;
      mask  <= '0;
    end else begin
      if (cfg_we && (cfg_addr == RA_MASK)) mask <= cfg_wdata[CZ_W-1:0];
      if (cfg_we && (cfg_addr == RA_CAUSE)) cause <= (cause & cfg_wdata[CZ_W-1:0]) | set_vec;
      else                                  cause <= cause | set_vec;
    end
  end

  assign irq = |(cause & mask);

  // R5: completion is recorded in cause bit 0
  p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> cause[CZ_DONE]);

  // R10: a zero write clears every cause when no event arrives with it
  p_clear_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_addr == RA_CAUSE) && (cfg_wdata[CZ_W-1:0] == '0)
      && !finish_evt && !abort_evt) |=> (cause == '0));

endmodule

// File: rtl/dma_fill_chan.sv
module dma_fill_chan
  import dma_fill_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int CW = 24,
  parameter int NW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              irq
);

  localparam int BEAT       = DW / 8;
  localparam int DESC_WORDS = 4;
  localparam int DIW        = $clog2(DESC_WORDS);
  localparam int WORD_SH    = 2;

  chan_state_e     state;
  logic [DIW-1:0]  desc_idx;
  logic            rd_done, beat_done, desc_ld, chain_start;
  logic            start_evt, finish_evt, abort_evt, busy;
  logic            go, hold, wide, kill;
  logic [CW-1:0]   count;
  logic [AW-1:0]   src, dst, nxt_ptr, cur_ptr;
  logic [31:0]     aux;
  logic [CZ_W-1:0] cause, mask;
  logic [DW-1:0]   data_q;

  dma_fill_fsm #(.DESC_WORDS(DESC_WORDS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .kill       (kill),
    .cnt_zero   (count == '0),
    .next_zero  (nxt_ptr == '0),
    .mem_ack    (mem_ack),
    .state      (state),
    .desc_idx   (desc_idx),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .rd_done    (rd_done),
    .beat_done  (beat_done),
    .desc_ld    (desc_ld),
    .chain_start(chain_start),
    .start_evt  (start_evt),
    .finish_evt (finish_evt),
    .abort_evt  (abort_evt),
    .busy       (busy)
  );

  dma_fill_regs #(.AW(AW), .CW(CW), .NW(NW), .BEAT(BEAT), .DIW(DIW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .busy       (busy),
    .start_evt  (start_evt),
    .beat_done  (beat_done),
    .chain_start(chain_start),
    .desc_ld    (desc_ld),
    .desc_idx   (desc_idx),
    .desc_word  (mem_rdata[31:0]),
    .finish_evt (finish_evt),
    .abort_evt  (abort_evt),
    .go         (go),
    .hold       (hold),
    .wide       (wide),
    .kill       (kill),
    .count      (count),
    .src        (src),
    .dst        (dst),
    .nxt_ptr    (nxt_ptr),
    .cur_ptr    (cur_ptr),
    .aux        (aux)
  );

  dma_fill_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .finish_evt(finish_evt),
    .abort_evt (abort_evt),
    .cause     (cause),
    .mask      (mask),
    .irq       (irq)
  );

  // Read data is held between the source read and the destination write.
  always_ff @(posedge clk) begin
    if (!rst_n)       data_q <= '0;
    else if (rd_done) data_q <= mem_rdata;
  end

  always_comb begin
    unique case (state)
      ST_READ:  mem_addr = src;
      ST_WRITE: mem_addr = dst;
      ST_DESC:  mem_addr = nxt_ptr + (AW'(desc_idx) << WORD_SH);
      default:  mem_addr = '0;
    endcase
  end

  assign mem_wdata = data_q;

  always_comb begin
    unique case (cfg_addr)
      RA_CTRL:  cfg_rdata = 32'({busy, 1'b0, wide, hold, go});
      RA_COUNT: cfg_rdata = 32'(count);
      RA_SRC:   cfg_rdata = 32'(src);
      RA_DST:   cfg_rdata = 32'(dst);
      RA_NEXT:  cfg_rdata = 32'(nxt_ptr);
      RA_CUR:   cfg_rdata = 32'(cur_ptr);
      RA_AUX:   cfg_rdata = aux;
      RA_CAUSE: cfg_rdata = 32'(cause);
      RA_MASK:  cfg_rdata = 32'(mask);
      default:  cfg_rdata = '0;
    endcase
  end

  // R3: a completed beat lowers the remaining count by one beat
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |=> (count == $past(count) - CW'(BEAT)));

  // R4: with source-hold the source address never moves on a beat
  p_hold_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && hold) |=> $stable(src));

  // R12: a pending request keeps its address and direction
  p_addr_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (!mem_req || ($stable(mem_addr) && $stable(mem_we))));

  // R6: a paused channel issues no new request
  p_pause_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !go && !mem_req) |=> !mem_req);

endmodule

// File: tb/dma_fill_chan_bench.sv
`timescale 1ns/100ps
module dma_fill_chan_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  dma_fill_chan u_dma_fill_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
  );

  // Register word indices and control bits as stated in the requirements
  localparam logic [3:0] A_CTRL = 0, A_COUNT = 1, A_SRC = 2, A_DST = 3,
                         A_NEXT = 4, A_CUR = 5, A_AUX = 6, A_CAUSE = 7, A_MASK = 8;
  localparam logic [31:0] C_GO = 32'h1, C_HOLD = 32'h2, C_WIDE = 32'h4,
                          C_KILL = 32'h8, C_BUSY = 32'h10;

  // Memory model: 256 words of 8 bytes, acknowledge in the second request cycle
  logic [63:0] mem [0:255];
  logic        wait_q;
  int          wr_beats = 0;

  always @(posedge clk) begin
    if (!rst_n) wait_q <= 1'b0;
    else        wait_q <= mem_req && !mem_ack;
  end
  assign mem_ack = mem_req && wait_q;
  assign mem_rdata = mem_addr[2] ? {32'h0, mem[mem_addr[10:3]][63:32]}
                                 : mem[mem_addr[10:3]];
  always @(posedge clk) begin
    if (mem_req && mem_we && mem_ack) begin
      mem[mem_addr[10:3]] <= mem_wdata;
      wr_beats <= wr_beats + 1;
    end
  end

  int n_checks = 0;
  int n_fails  = 0;

  // Request-stability monitor for R12
  int          r12_viol = 0;
  logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0;
  always @(negedge clk) begin
    if (rst_n && p_req && !p_ack && mem_req && (mem_addr != p_addr || mem_we != p_we))
      r12_viol = r12_viol + 1;
    p_req  = mem_req;
    p_ack  = mem_ack;
    p_we   = mem_we;
    p_addr = mem_addr;
  end

  function automatic logic [63:0] pat(int i);
    return {16'hA500, 16'(i), 16'h3C00, ~16'(i)};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_read(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_idle(string req);
    logic [31:0] c;
    int n = 0;
    do begin
      reg_read(A_CTRL, c);
      n++;
    end while ((c & C_BUSY) != 0 && n < 5000);
    check(req, c & C_BUSY, 0);
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
  endtask

  task automatic zero_words(int first, int n);
    for (int i = 0; i < n; i++) mem[first + i] = 64'h0;
  endtask

  // {src, dst, count, flags(bit0 hold, bit1 wide)}
  localparam logic [95:0] VEC [0:3] = '{
    {32'h100, 32'h400, 24'h000020, 8'h02},
    {32'h108, 32'h500, 24'h000008, 8'h02},
    {32'h200, 32'h600, 24'h000030, 8'h03},
    {32'h180, 32'h680, 24'h030040, 8'h00}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [31:0] d, snap_cnt;
    int snap_wr;
    fill_mem();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a <= 8; a++) begin
      reg_read(4'(a), d);
      check("R1", d, 0);
    end
    check("R1", irq, 0);
    check("R1", mem_req, 0);

    // Table of copy, fill and narrow-count transfers
    for (int v = 0; v < 4; v++) begin
      logic [31:0] s, t, eff;
      logic [23:0] cnt;
      logic hold, wide;
      int beats;
      string tag;
      s = VEC[v][95:64]; t = VEC[v][63:32]; cnt = VEC[v][31:8];
      hold = VEC[v][0]; wide = VEC[v][1];
      eff = wide ? 32'(cnt) : 32'(cnt[15:0]);
      beats = int'(eff / 8);
      tag = hold ? "R4" : (wide ? "R3" : "R9");
      fill_mem();
      zero_words(int'(t >> 3), beats + 1);
      reg_write(A_CAUSE, 0);
      reg_write(A_COUNT, 32'(cnt));
      reg_write(A_SRC, s);
      reg_write(A_DST, t);
      reg_write(A_NEXT, 0);
      reg_write(A_CTRL, C_GO | (hold ? C_HOLD : 0) | (wide ? C_WIDE : 0));
      wait_idle("R5");
      for (int k = 0; k < beats; k++)
        check(tag, mem[int'(t >> 3) + k], hold ? pat(int'(s >> 3)) : pat(int'(s >> 3) + k));
      check(tag, mem[int'(t >> 3) + beats], 64'h0);
      reg_read(A_COUNT, d); check(tag, d, 0);
      reg_read(A_SRC, d);   check(tag, d, hold ? s : s + eff);
      reg_read(A_DST, d);   check(tag, d, t + eff);
      reg_read(A_CAUSE, d); check("R5", d, 1);
      reg_read(A_CTRL, d);  check("R5", d & C_GO, 0);
    end

    // R6, R11, R2: pause, ignored writes, resume
    fill_mem();
    zero_words(32'h80, 33);
    reg_write(A_CAUSE, 0);
    reg_write(A_COUNT, 32'h100);
    reg_write(A_SRC, 32'h0);
    reg_write(A_DST, 32'h400);
    reg_write(A_CTRL, C_GO | C_WIDE);
    reg_read(A_CTRL, d);
    check("R2", d, C_BUSY | C_WIDE | C_GO);
    repeat (20) @(negedge clk);
    reg_write(A_CTRL, C_WIDE);
    repeat (10) @(negedge clk);
    reg_read(A_CTRL, d);
    check("R6", d, C_BUSY | C_WIDE);
    reg_read(A_COUNT, snap_cnt);
    snap_wr = wr_beats;
    repeat (30) @(negedge clk);
    reg_read(A_COUNT, d);
    check("R6", d, snap_cnt);
    check("R6", 64'(wr_beats), 64'(snap_wr));
    check("R6", mem_req, 0);
    reg_write(A_COUNT, 32'h8);
    reg_write(A_DST, 32'h7F8);
    reg_read(A_COUNT, d);
    check("R11", d, snap_cnt);
    reg_read(A_DST, d);
    check("R11", d, 32'h400 + (32'h100 - snap_cnt));
    reg_write(A_CTRL, C_GO | C_WIDE);
    wait_idle("R6");
    for (int k = 0; k < 32; k++) check("R6", mem[32'h80 + k], pat(k));
    check("R6", mem[32'hA0], 64'h0);
    reg_read(A_CAUSE, d);
    check("R6", d, 1);

    // R7: kill mid-transfer
    fill_mem();
    reg_write(A_CAUSE, 0);
    reg_write(A_COUNT, 32'h100);
    reg_write(A_SRC, 32'h0);
    reg_write(A_DST, 32'h400);
    reg_write(A_CTRL, C_GO | C_WIDE);
    repeat (20) @(negedge clk);
    reg_write(A_CTRL, C_KILL | C_GO | C_WIDE);
    check("R7", mem_req, 0);
    repeat (2) @(negedge clk);
    reg_read(A_CTRL, d);
    check("R7", d, C_WIDE);
    reg_read(A_COUNT, d);
    check("R7", (d != 0) && (d < 32'h100), 1);
    reg_read(A_CAUSE, d);
    check("R7", d, 2);

    // R5: zero count completes with no memory write
    reg_write(A_CAUSE, 0);
    snap_wr = wr_beats;
    reg_write(A_COUNT, 0);
    reg_write(A_NEXT, 0);
    reg_write(A_CTRL, C_GO | C_WIDE);
    wait_idle("R5");
    check("R5", 64'(wr_beats), 64'(snap_wr));
    reg_read(A_CAUSE, d);
    check("R5", d, 1);

    // R8: chained descriptor at 0x300
    fill_mem();
    mem[32'h60] = {32'h40, 32'h18};
    mem[32'h61] = {32'h0, 32'h780};
    zero_words(32'hE0, 3);
    zero_words(32'hF0, 4);
    reg_write(A_CAUSE, 0);
    reg_write(A_COUNT, 32'h10);
    reg_write(A_SRC, 32'h0);
    reg_write(A_DST, 32'h700);
    reg_write(A_NEXT, 32'h300);
    reg_write(A_CTRL, C_GO | C_WIDE);
    wait_idle("R8");
    check("R8", mem[32'hE0], pat(0));
    check("R8", mem[32'hE1], pat(1));
    check("R8", mem[32'hE2], 64'h0);
    check("R8", mem[32'hF0], pat(8));
    check("R8", mem[32'hF1], pat(9));
    check("R8", mem[32'hF2], pat(10));
    check("R8", mem[32'hF3], 64'h0);
    reg_read(A_CUR, d);  check("R8", d, 32'h300);
    reg_read(A_NEXT, d); check("R8", d, 0);
    reg_read(A_DST, d);  check("R8", d, 32'h798);
    reg_read(A_CAUSE, d); check("R8", d, 1);

    // R10: cause, mask, irq and the storage register
    check("R10", irq, 0);
    reg_write(A_MASK, 1);
    check("R10", irq, 1);
    reg_write(A_CAUSE, 0);
    reg_read(A_CAUSE, d);
    check("R10", d, 0);
    check("R10", irq, 0);
    reg_write(A_AUX, 32'hDEAD_BEEF);
    reg_read(A_AUX, d);
    check("R10", d, 32'hDEAD_BEEF);

    // R12: no request changed before its acknowledge
    check("R12", 64'(r12_viol), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule